// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 18-bit words. A producer writes on its own clock and a consumer reads on a second, unrelated clock. Either clock may be the faster one, and both sides may be active in the same cycle. Write and read pointers cross between the domains as Gray code through two-flop synchronisers. Full, half-full and almost-full are computed in the write domain. Empty and almost-empty are computed in the read domain.

Two thresholds set the almost flags. Master reset loads them from one of two built-in pairs, chosen by a select pin. Software can then reprogram them in either of two ways: bit by bit over a serial pair, or as whole words through the write data bus. Partial reset discards the buffered data but keeps whatever thresholds were programmed last. Master reset also latches the read timing. In standard timing a word appears only after a read request. In fall-through timing the oldest word is presented on the output without a request. A retransmit strobe rewinds the read side to the first stored location, so data written since reset can be replayed.

Top module: `dcflag_fifo`

## Requirements
- R1: While master reset (`mstRstN`, active low, asynchronous) is low, all words are discarded. After release in standard timing: `rdStat`=1 (empty), `wrStat`=0 (not full), `halfFull`=0, `almostEmpty`=1, `almostFull`=0.
- R2: Words leave in the order they were accepted, with both clocks running and reads and writes overlapping.
- R3: In standard timing `wrStat`=1 once the buffer holds DEPTH (16) words. A data write (`wrEn`=1, `cfgLoad`=0) while full is dropped and leaves the stored contents unchanged.
- R4: In standard timing `rdStat`=1 when no word is stored. A read while empty leaves `rdData` and the read pointer unchanged.
- R5: `halfFull` is 1 exactly when the write-side word count exceeds DEPTH/2 (8).
- R6: `almostEmpty` is 1 when the read-side word count is at or below the almost-empty threshold. In fall-through timing this count includes a word waiting on the output.
- R7: `almostFull` is 1 when the free space (DEPTH minus the write-side count) is at or below the almost-full threshold.
- R8: On master reset, `defSel`=0 loads thresholds almost-empty 2 and almost-full 3, and `defSel`=1 loads 5 and 6.
- R9: While `cfgLoad`=1, each `wrEn` strobe writes `wrData[3:0]` into a threshold instead of the buffer. The first strobe after a reset goes to almost-empty, the second to almost-full, and the target then alternates.
- R10: Each write-clock cycle with `cfgSerEn`=1 shifts `cfgSerIn` into the thresholds. The 8 bits are sent almost-empty bit 0 first, through bit 3, then almost-full bit 0 through bit 3.
- R11: Partial reset (`prtRstN`, active low) empties the buffer the same way master reset does, but keeps the programmed thresholds and the latched timing mode.
- R12: With `fwftSel`=1 at master reset, `rdStat` means output-ready and `wrStat` means input-ready. The oldest word is placed on `rdData` without a read and held there until read. `rdEn` consumes it.
- R13: A one-cycle `rtReq` moves the read side back to location 0. In standard timing the first stored word can be read on the next read-clock cycle.
- R14: After a write into an empty buffer, `rdStat` changes on the 2nd read-clock edge in standard timing and on the 3rd in fall-through timing, whatever the clock ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| mstRstN | input | 1 | Master reset, active low; restores default thresholds and latches the mode selects |
| prtRstN | input | 1 | Partial reset, active low; keeps thresholds and mode |
| defSel | input | 1 | Selects the default threshold pair at master reset |
| fwftSel | input | 1 | 1 selects fall-through timing at master reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 18 | Write data; low 4 bits carry a threshold during parallel load |
| cfgLoad | input | 1 | Routes write strobes to the threshold registers |
| cfgSerEn | input | 1 | Serial threshold shift enable |
| cfgSerIn | input | 1 | Serial threshold bit |
| rdEn | input | 1 | Read strobe |
| rtReq | input | 1 | Retransmit request, read domain |
| rdData | output | 18 | Output data register |
| rdStat | output | 1 | Empty (standard) or output-ready (fall-through) |
| wrStat | output | 1 | Full (standard) or input-ready (fall-through) |
| halfFull | output | 1 | Word count above half the depth |
| almostEmpty | output | 1 | Count at or below the almost-empty threshold |
| almostFull | output | 1 | Free space at or below the almost-full threshold |

## Verification
The hardest case to reach is a flag crossing its threshold by exactly one word after it has been reprogrammed, because each flag settles only after the other domain's pointer has passed through the synchroniser. The stimulus therefore writes one word at a time and waits several edges of both clocks before it samples. This is done under the default pairs, after a parallel load, after a serial load, and again after a partial reset. The two clocks have co-prime periods and a fractional phase offset, so their edges never line up. This lets the bench count read-clock edges from a write edge to the empty flag and check that the latency is fixed.

// File: rtl/dcflag_fifo_pkg.sv
`timescale 1ns/100ps
package dcflag_fifo_pkg;
  typedef struct packed {
    logic memWr;
    logic outLoad;
  } fifoStrb_t;
endpackage

// File: rtl/dcflag_fifo_sync.sv
`timescale 1ns/100ps
module dcflag_fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcflag_fifo_dp.sv
`timescale 1ns/100ps
module dcflag_fifo_dp
  import dcflag_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.outLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/dcflag_fifo_ctrl.sv
`timescale 1ns/100ps
module dcflag_fifo_ctrl
  import dcflag_fifo_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int AE_DEF0 = 2,
  parameter int AF_DEF0 = 3,
  parameter int AE_DEF1 = 5,
  parameter int AF_DEF1 = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              prtRstN,
  input  logic              defSel,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] cfgWord,
  input  logic              cfgLoad,
  input  logic              cfgSerEn,
  input  logic              cfgSerIn,
  input  logic              rdEn,
  input  logic              rtReq,
  output fifoStrb_t         strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullW,
  output logic              emptyR,
  output logic              outValid,
  output logic              fwftMode,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int OFF_W = ADDR_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstN;
  assign rstN = mstRstN & prtRstN;

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrPtr, wrGray, rdGraySync, rdPtrW, wrCount, freeW;
  logic [OFF_W-1:0] aeOff, afOff;
  logic             cfgIdx;

  dcflag_fifo_sync #(.W(PTR_W)) rdToWr_i (
    .clk(wrClk), .rstN(rstN), .d(toGray(rdPtrR)), .q(rdGraySync)
  );

  assign rdPtrW  = fromGray(rdGraySync);
  assign wrCount = wrPtr - rdPtrW;
  assign freeW   = DEPTH_P - wrCount;
  assign fullW   = (wrCount == DEPTH_P);
  assign halfFull   = (wrCount > HALF_P);
  assign almostFull = (freeW <= PTR_W'(afOff));
  assign strb.memWr = wrEn & ~cfgLoad & ~fullW;
  assign wrAddr     = wrPtr[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      cfgIdx <= 1'b0;
    end else begin
      if (strb.memWr) begin
        wrPtr  <= wrPtr + 1'b1;
        wrGray <= toGray(wrPtr + 1'b1);
      end
      if (cfgLoad && wrEn) cfgIdx <= ~cfgIdx;
    end
  end

  // thresholds and mode: loaded while master reset is held, kept through partial reset
  always_ff @(posedge wrClk) begin
    if (!mstRstN) begin
      fwftMode <= fwftSel;
      aeOff    <= defSel ? OFF_W'(AE_DEF1) : OFF_W'(AE_DEF0);
      afOff    <= defSel ? OFF_W'(AF_DEF1) : OFF_W'(AF_DEF0);
    end else if (cfgSerEn) begin
      {afOff, aeOff} <= {cfgSerIn, afOff, aeOff[OFF_W-1:1]};
    end else if (cfgLoad && wrEn) begin
      if (cfgIdx) afOff <= cfgWord;
      else        aeOff <= cfgWord;
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdPtrR, wrGraySync, wrPtrR, rdCount, aeCount;
  logic             stdRead, fetch;

  dcflag_fifo_sync #(.W(PTR_W)) wrToRd_i (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign wrPtrR  = fromGray(wrGraySync);
  assign rdCount = wrPtrR - rdPtrR;
  assign emptyR  = (rdCount == '0);
  assign aeCount = rdCount + PTR_W'(fwftMode & outValid);
  assign almostEmpty = (aeCount <= PTR_W'(aeOff));

  assign stdRead = ~fwftMode & rdEn & ~emptyR;
  assign fetch   = fwftMode & ~emptyR & (~outValid | rdEn);
  assign strb.outLoad = ~rtReq & (stdRead | fetch);
  assign rdAddr  = rdPtrR[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtrR   <= '0;
      outValid <= 1'b0;
    end else if (rtReq) begin
      rdPtrR   <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.outLoad) rdPtrR <= rdPtrR + 1'b1;
      if (fetch)        outValid <= 1'b1;
      else if (rdEn)    outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/dcflag_fifo.sv
`timescale 1ns/100ps
module dcflag_fifo
  import dcflag_fifo_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 4,
  parameter int AE_DEF0 = 2,
  parameter int AF_DEF0 = 3,
  parameter int AE_DEF1 = 5,
  parameter int AF_DEF1 = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              prtRstN,
  input  logic              defSel,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLoad,
  input  logic              cfgSerEn,
  input  logic              cfgSerIn,
  input  logic              rdEn,
  input  logic              rtReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStat,
  output logic              wrStat,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  fifoStrb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              fullW, emptyR, outValid, fwftMode, rstN;

  assign rstN = mstRstN & prtRstN;

  dcflag_fifo_ctrl #(
    .ADDR_W(ADDR_W), .AE_DEF0(AE_DEF0), .AF_DEF0(AF_DEF0),
    .AE_DEF1(AE_DEF1), .AF_DEF1(AF_DEF1)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .defSel(defSel), .fwftSel(fwftSel), .wrEn(wrEn),
    .cfgWord(wrData[ADDR_W-1:0]), .cfgLoad(cfgLoad), .cfgSerEn(cfgSerEn),
    .cfgSerIn(cfgSerIn), .rdEn(rdEn), .rtReq(rtReq), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .fullW(fullW), .emptyR(emptyR),
    .outValid(outValid), .fwftMode(fwftMode), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  dcflag_fifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  assign rdStat = fwftMode ? outValid : emptyR;
  assign wrStat = fwftMode ? ~fullW : fullW;
endmodule

// File: rtl/dcflag_fifo_chk.sv
`timescale 1ns/100ps
module dcflag_fifo_chk #(
  parameter int DATA_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              mstRstN,
  input logic              prtRstN,
  input logic              fwftMode,
  input logic              fullW,
  input logic              emptyR,
  input logic              halfFull,
  input logic              almostEmpty,
  input logic              almostFull,
  input logic              rdEn,
  input logic              rtReq,
  input logic              rdStat,
  input logic [DATA_W-1:0] rdData
);
  logic rstN;
  assign rstN = mstRstN & prtRstN;

  AST_FULL_IS_HALF: assert property (@(posedge wrClk) disable iff (!rstN)
    fullW |-> halfFull); // R5

  AST_FULL_IS_ALMOST: assert property (@(posedge wrClk) disable iff (!rstN)
    fullW |-> almostFull); // R7

  AST_EMPTY_IS_ALMOST: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyR && !fwftMode) |-> almostEmpty); // R6

  AST_EMPTY_READ_HOLDS: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && emptyR && rdEn && !rtReq) |=> $stable(rdData)); // R4

  AST_FWFT_WORD_HOLDS: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && rdStat && !rdEn && !rtReq) |=> (rdStat && $stable(rdData))); // R12
endmodule

bind dcflag_fifo dcflag_fifo_chk #(.DATA_W(DATA_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
  .fwftMode(fwftMode), .fullW(fullW), .emptyR(emptyR), .halfFull(halfFull),
  .almostEmpty(almostEmpty), .almostFull(almostFull), .rdEn(rdEn),
  .rtReq(rtReq), .rdStat(rdStat), .rdData(rdData)
);

// File: tb/dcflag_fifo_tb_top.sv
`timescale 1ns/100ps
module dcflag_fifo_tb_top;
  logic wrClk = 1'b0, rdClk = 1'b0;
  logic mstRstN = 1'b0, prtRstN = 1'b1, defSel = 1'b0, fwftSel = 1'b0;
  logic wrEn = 1'b0, cfgLoad = 1'b0, cfgSerEn = 1'b0, cfgSerIn = 1'b0;
  logic rdEn = 1'b0, rtReq = 1'b0;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic rdStat, wrStat, halfFull, almostEmpty, almostFull;

  int checks = 0, errors = 0;
  bit benchFwft = 0, done = 0;
  logic [17:0] expQ[$];

  always #2.5 wrClk = ~wrClk;
  initial begin
    #1.2;
    forever #3.5 rdClk = ~rdClk;
  end

  dcflag_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .defSel(defSel), .fwftSel(fwftSel), .wrEn(wrEn), .wrData(wrData),
    .cfgLoad(cfgLoad), .cfgSerEn(cfgSerEn), .cfgSerIn(cfgSerIn),
    .rdEn(rdEn), .rtReq(rtReq), .rdData(rdData), .rdStat(rdStat),
    .wrStat(wrStat), .halfFull(halfFull), .almostEmpty(almostEmpty),
    .almostFull(almostFull)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as words leave the design
  bit pending = 0;
  always @(negedge rdClk) begin
    if (pending) begin
      if (expQ.size() == 0) chk(0, "R2 unexpected word", 32'(rdData), 0);
      else begin
        logic [17:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R2 data order", 32'(rdData), 32'(e));
      end
    end
    pending = 0;
    if (!benchFwft && rdEn && !rdStat && !rtReq) pending = 1;
    if (benchFwft && rdEn && rdStat && !rtReq) begin
      if (expQ.size() == 0) chk(0, "R12 unexpected word", 32'(rdData), 0);
      else begin
        logic [17:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R12 fall-through data", 32'(rdData), 32'(e));
      end
    end
  end

  task automatic writeBurst(input int n, input logic [17:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge wrClk); #0.1;
      wrEn = 1'b1; wrData = base + 18'(i);
      @(negedge wrClk);
      if (!cfgLoad && (benchFwft ? wrStat : !wrStat)) expQ.push_back(wrData);
    end
    @(posedge wrClk); #0.1;
    wrEn = 1'b0;
  endtask

  task automatic readN(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rdClk); #0.1;
      rdEn = 1'b1;
    end
    @(posedge rdClk); #0.1;
    rdEn = 1'b0;
    @(negedge rdClk); #0.1;
  endtask

  task automatic settle();
    repeat (4) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    #0.3;
  endtask

  task automatic doReset(input bit master, input bit fwft, input bit dsel);
    @(posedge wrClk); #0.1;
    fwftSel = fwft; defSel = dsel;
    if (master) mstRstN = 1'b0; else prtRstN = 1'b0;
    repeat (4) @(posedge wrClk);
    #0.1;
    mstRstN = 1'b1; prtRstN = 1'b1;
    expQ.delete();
    if (master) benchFwft = fwft;
    settle();
  endtask

  task automatic parLoad(input logic [3:0] ae, input logic [3:0] af);
    @(posedge wrClk); #0.1;
    cfgLoad = 1'b1; wrEn = 1'b1; wrData = 18'(ae);
    @(posedge wrClk); #0.1;
    wrData = 18'(af);
    @(posedge wrClk); #0.1;
    wrEn = 1'b0; cfgLoad = 1'b0;
  endtask

  task automatic serLoad(input logic [3:0] ae, input logic [3:0] af);
    logic [7:0] bits;
    bits = {af, ae};
    for (int i = 0; i < 8; i++) begin
      @(posedge wrClk); #0.1;
      cfgSerEn = 1'b1; cfgSerIn = bits[i];
    end
    @(posedge wrClk); #0.1;
    cfgSerEn = 1'b0;
  endtask

  initial begin
    int n;
    // R1 reset state
    doReset(1, 0, 0);
    chk(rdStat == 1, "R1 empty after reset", 32'(rdStat), 1);
    chk(wrStat == 0, "R1 not full after reset", 32'(wrStat), 0);
    chk(halfFull == 0, "R1 halfFull after reset", 32'(halfFull), 0);
    chk(almostEmpty == 1, "R1 almostEmpty after reset", 32'(almostEmpty), 1);
    chk(almostFull == 0, "R1 almostFull after reset", 32'(almostFull), 0);

    // R4 read while empty is ignored
    readN(3);
    chk(rdData == 0, "R4 rdData unchanged on empty read", 32'(rdData), 0);
    chk(rdStat == 1, "R4 still empty", 32'(rdStat), 1);

    // R14 fixed first-word latency, standard timing
    writeBurst(1, 18'h100);
    n = 0;
    while (rdStat && n < 10) begin
      @(posedge rdClk); #0.1;
      n++;
    end
    chk(n == 2, "R14 standard latency edges", 32'(n), 2);
    settle();
    chk(almostEmpty == 1, "R6 count 1 <= 2", 32'(almostEmpty), 1);
    writeBurst(1, 18'h101); settle();
    chk(almostEmpty == 1, "R6 count 2 <= 2", 32'(almostEmpty), 1);
    writeBurst(1, 18'h102); settle();
    chk(almostEmpty == 0, "R6 count 3 > 2", 32'(almostEmpty), 0);
    writeBurst(5, 18'h103); settle();
    chk(halfFull == 0, "R5 count 8", 32'(halfFull), 0);
    writeBurst(1, 18'h108); settle();
    chk(halfFull == 1, "R5 count 9", 32'(halfFull), 1);
    writeBurst(3, 18'h109); settle();
    chk(almostFull == 0, "R7 free 4 > 3", 32'(almostFull), 0);
    writeBurst(1, 18'h10C); settle();
    chk(almostFull == 1, "R7 free 3 <= 3", 32'(almostFull), 1);
    writeBurst(3, 18'h10D); settle();
    chk(wrStat == 1, "R3 full at 16", 32'(wrStat), 1);
    chk(expQ.size() == 16, "R3 accepted count", 32'(expQ.size()), 16);
    writeBurst(3, 18'h2A0); settle();
    chk(wrStat == 1, "R3 still full after dropped writes", 32'(wrStat), 1);
    chk(expQ.size() == 16, "R3 dropped writes not accepted", 32'(expQ.size()), 16);
    readN(20); settle();
    chk(expQ.size() == 0, "R3 drained all accepted words", 32'(expQ.size()), 0);
    chk(rdStat == 1, "R4 empty after drain", 32'(rdStat), 1);

    // R2 overlapping traffic with back-pressure
    fork
      writeBurst(40, 18'h3000);
      readN(70);
    join
    settle();
    readN(5);
    chk(expQ.size() == 0, "R2 concurrent traffic drained", 32'(expQ.size()), 0);

    // R9 parallel threshold load: ae=3, af=4
    doReset(0, 0, 0);
    parLoad(4'd3, 4'd4); settle();
    chk(rdStat == 1, "R9 config writes stay out of buffer", 32'(rdStat), 1);
    writeBurst(3, 18'h400); settle();
    chk(almostEmpty == 1, "R9 ae=3 at count 3", 32'(almostEmpty), 1);
    writeBurst(1, 18'h403); settle();
    chk(almostEmpty == 0, "R9 ae=3 at count 4", 32'(almostEmpty), 0);
    writeBurst(7, 18'h404); settle();
    chk(almostFull == 0, "R9 af=4 at free 5", 32'(almostFull), 0);
    writeBurst(1, 18'h40B); settle();
    chk(almostFull == 1, "R9 af=4 at free 4", 32'(almostFull), 1);
    readN(14); settle();
    chk(expQ.size() == 0, "R2 drain after R9", 32'(expQ.size()), 0);

    // R10 serial threshold load: ae=1, af=6
    doReset(0, 0, 0);
    serLoad(4'd1, 4'd6); settle();
    writeBurst(1, 18'h500); settle();
    chk(almostEmpty == 1, "R10 ae=1 at count 1", 32'(almostEmpty), 1);
    writeBurst(1, 18'h501); settle();
    chk(almostEmpty == 0, "R10 ae=1 at count 2", 32'(almostEmpty), 0);
    writeBurst(7, 18'h502); settle();
    chk(almostFull == 0, "R10 af=6 at free 7", 32'(almostFull), 0);
    writeBurst(1, 18'h509); settle();
    chk(almostFull == 1, "R10 af=6 at free 6", 32'(almostFull), 1);

    // R11 partial reset clears data, keeps thresholds
    doReset(0, 0, 0);
    chk(rdStat == 1, "R11 empty after partial reset", 32'(rdStat), 1);
    chk(wrStat == 0, "R11 not full after partial reset", 32'(wrStat), 0);
    writeBurst(2, 18'h600); settle();
    chk(almostEmpty == 0, "R11 ae=1 kept at count 2", 32'(almostEmpty), 0);
    readN(3); settle();
    chk(expQ.size() == 0, "R11 only new words read", 32'(expQ.size()), 0);

    // R8 master reset with second default pair: ae=5, af=6
    doReset(1, 0, 1);
    writeBurst(5, 18'h700); settle();
    chk(almostEmpty == 1, "R8 ae=5 at count 5", 32'(almostEmpty), 1);
    writeBurst(1, 18'h705); settle();
    chk(almostEmpty == 0, "R8 ae=5 at count 6", 32'(almostEmpty), 0);
    writeBurst(3, 18'h706); settle();
    chk(almostFull == 0, "R8 af=6 at free 7", 32'(almostFull), 0);
    writeBurst(1, 18'h709); settle();
    chk(almostFull == 1, "R8 af=6 at free 6", 32'(almostFull), 1);
    readN(12); settle();

    // R13 retransmit replays from location 0
    doReset(1, 0, 0);
    writeBurst(4, 18'h800); settle();
    readN(2);
    chk(expQ.size() == 2, "R13 two words consumed", 32'(expQ.size()), 2);
    @(posedge rdClk); #0.1; rtReq = 1'b1;
    @(posedge rdClk); #0.1; rtReq = 1'b0;
    expQ.delete();
    for (int i = 0; i < 4; i++) expQ.push_back(18'h800 + 18'(i));
    @(negedge rdClk); #0.1;
    chk(rdStat == 0, "R13 readable after retransmit", 32'(rdStat), 0);
    readN(4); settle();
    chk(expQ.size() == 0, "R13 replay complete", 32'(expQ.size()), 0);
    chk(rdStat == 1, "R13 empty after replay", 32'(rdStat), 1);

    // R12 fall-through timing
    doReset(1, 1, 0);
    chk(rdStat == 0, "R12 output not ready after reset", 32'(rdStat), 0);
    chk(wrStat == 1, "R12 input ready after reset", 32'(wrStat), 1);
    writeBurst(1, 18'h900);
    n = 0;
    while (!rdStat && n < 10) begin
      @(posedge rdClk); #0.1;
      n++;
    end
    chk(n == 3, "R14 fall-through latency edges", 32'(n), 3);
    chk(rdData == 18'h900, "R12 word presented without read", 32'(rdData), 32'h900);
    settle();
    chk(almostEmpty == 1, "R6 fall-through count 1", 32'(almostEmpty), 1);
    writeBurst(2, 18'h901); settle();
    chk(almostEmpty == 0, "R6 fall-through count 3", 32'(almostEmpty), 0);
    chk(rdData == 18'h900, "R12 word held until read", 32'(rdData), 32'h900);
    readN(3); settle();
    chk(expQ.size() == 0, "R12 all words consumed", 32'(expQ.size()), 0);
    chk(rdStat == 0, "R12 output not ready when drained", 32'(rdStat), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule